// File: doc/BRIEF.md
# Software-Managed Translation Table

This block holds a fully associative table of address translations, each entry covering an even/odd pair of virtual pages and naming one physical frame for each half. Software fills and inspects the table through a small set of 32-bit staging values: a page-size mask, a virtual-page/address-space word, two frame words (one per half of the pair), an index and a random slot number. The block performs one table operation per clock, selected by a 3-bit operation code. There are five operations. Two write the table: one at the slot named by the index and one at the slot named by the random value. Read-back returns a stored entry in the staging format. A probe searches for the staging virtual page and address space.

The caller presents the staging inputs together with an operation code. A write updates the table at the clock edge. A read-back updates the four staging outputs at the next edge. A probe matches every entry in parallel in one cycle, and a lowest-slot-first priority encoder picks the result. The index output is registered at the next edge. Each output holds its value until an operation that is allowed to change it arrives.

Top module: `tlb_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all five outputs become zero. Every table entry becomes all-zero: mask 0, VPN2 0, ASID 0, global 0, both valid bits 0.
- R2: An indexed write (op 1) selects the slot with `index_i[5:0]`. A random write (op 2) selects it with `random_i[5:0]`. All other bits of those two inputs have no effect on the slot chosen.
- R3: A write whose 6-bit slot number is ENTRIES (48) or above changes no entry.
- R4: A write stores six fields. The mask is `pagemask_i[24:13]`. VPN2 is `entryhi_i[31:13]` with its low 12 bits cleared wherever the mask is 1. The ASID is `entryhi_i[7:0]`. The global bit is `entrylo0_i[0] & entrylo1_i[0]`. Each frame number is `entrylo*_i[25:6]` with its low 12 bits cleared wherever the mask is 1. The flags are `entrylo*_i[5:1]`, where bit 1 is the valid bit of that half.
- R5: A read-back (op 3) uses slot `index_i[4:0]` and updates the staging outputs one edge later. `pagemask_o` is the mask placed at bits [24:13]. `entryhi_o` is {VPN2, 5'b0, ASID}. Each `entrylo*_o` is {6'b0, frame, flags, global}. All other bits are zero.
- R6: An entry matches a probe when its VPN2 equals `entryhi_i[31:13]` with the entry's mask bits cleared. In addition, either its global bit must be 1 or its ASID must equal `entryhi_i[7:0]`. The valid bits are not consulted, so a cleared entry 0 matches VPN2 0 with ASID 0.
- R7: When several entries match a probe (op 4), `index_o` becomes the lowest matching slot number, zero-extended, one edge later.
- R8: When no entry matches a probe, `index_o` becomes 32'h8000_0000.
- R9: Only a probe changes `index_o`. Only a read-back changes the four staging outputs. Writes and idle cycles leave all outputs unchanged.
- R10: Operation codes 0, 5, 6 and 7 are idle. They change neither the table nor any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation: 0 idle, 1 indexed write, 2 random write, 3 read-back, 4 probe |
| index_i | input | 32 | Index staging value (slot for write and read-back) |
| random_i | input | 32 | Random staging value (slot for random write) |
| pagemask_i | input | 32 | Page-size mask staging value |
| entryhi_i | input | 32 | Virtual page pair and address-space staging value |
| entrylo0_i | input | 32 | Even-page frame staging value |
| entrylo1_i | input | 32 | Odd-page frame staging value |
| index_o | output | 32 | Probe result: slot number or miss code |
| pagemask_o | output | 32 | Read-back mask |
| entryhi_o | output | 32 | Read-back virtual page pair and address space |
| entrylo0_o | output | 32 | Read-back even-page frame word |
| entrylo1_o | output | 32 | Read-back odd-page frame word |

## Verification
The bench builds the block with its default of 48 entries. With that value, the 6-bit write selector can name slots 48 to 63, which must be dropped, and the 5-bit read-back selector wraps before reaching the upper 16 slots. Both edges therefore lie within direct reach. A reference model in the bench tracks the table from the stated field rules. It is used to check masked VPN2 and frame bits, the folded global bit, and the probe priority between duplicate entries. It also covers the case where a freshly reset entry 0 answers a probe for VPN2 0 with ASID 0.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int WORD_W    = 32;
    localparam int VPN_W     = 19;
    localparam int MASK_W    = 12;
    localparam int ASID_W    = 8;
    localparam int PFN_W     = 20;
    localparam int FLAG_W    = 5;
    localparam int WR_SEL_W  = 6;
    localparam int RD_SEL_W  = 5;
    localparam logic [WORD_W-1:0] MISS_CODE = 32'h8000_0000;

    typedef enum logic [2:0] {
        OP_IDLE      = 3'd0,
        OP_WRITE_IDX = 3'd1,
        OP_WRITE_RND = 3'd2,
        OP_READ      = 3'd3,
        OP_PROBE     = 3'd4
    } tlb_op_e;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic [VPN_W-1:0]  vpn2;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic [PFN_W-1:0]  pfn0;
        logic [FLAG_W-1:0] fl0;
        logic [PFN_W-1:0]  pfn1;
        logic [FLAG_W-1:0] fl1;
    } tlb_entry_t;

    function automatic logic [VPN_W-1:0] clear_vpn(input logic [VPN_W-1:0] v,
                                                   input logic [MASK_W-1:0] m);
        return v & ~{{(VPN_W-MASK_W){1'b0}}, m};
    endfunction

    function automatic logic [PFN_W-1:0] clear_pfn(input logic [PFN_W-1:0] p,
                                                   input logic [MASK_W-1:0] m);
        return p & ~{{(PFN_W-MASK_W){1'b0}}, m};
    endfunction

    function automatic tlb_entry_t build_entry(
        input logic [MASK_W-1:0] m,
        input logic [VPN_W-1:0]  v,
        input logic [ASID_W-1:0] a,
        input logic [PFN_W-1:0]  p0,
        input logic [FLAG_W-1:0] f0,
        input logic              g0,
        input logic [PFN_W-1:0]  p1,
        input logic [FLAG_W-1:0] f1,
        input logic              g1);
        tlb_entry_t e;
        e.mask = m;
        e.vpn2 = clear_vpn(v, m);
        e.asid = a;
        e.glob = g0 & g1;
        e.pfn0 = clear_pfn(p0, m);
        e.fl0  = f0;
        e.pfn1 = clear_pfn(p1, m);
        e.fl1  = f1;
        return e;
    endfunction

    function automatic logic [WORD_W-1:0] rb_mask(input tlb_entry_t e);
        return {{(WORD_W-MASK_W-13){1'b0}}, e.mask, 13'b0};
    endfunction

    function automatic logic [WORD_W-1:0] rb_hi(input tlb_entry_t e);
        return {e.vpn2, 5'b0, e.asid};
    endfunction

    function automatic logic [WORD_W-1:0] rb_lo(input logic [PFN_W-1:0] p,
                                                input logic [FLAG_W-1:0] f,
                                                input logic g);
        return {{(WORD_W-PFN_W-FLAG_W-1){1'b0}}, p, f, g};
    endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WR_SEL_W-1:0] wr_sel,
    input  tlb_entry_t          wr_data,
    input  logic [RD_SEL_W-1:0] rd_sel,
    output tlb_entry_t          rd_data,
    output tlb_entry_t          table_o [ENTRIES]
);

    tlb_entry_t table_q [ENTRIES];

    // One register bank per slot; a selector above ENTRIES hits no bank.
    for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
        localparam logic [WR_SEL_W-1:0] SLOT_ID = WR_SEL_W'(s);
        always_ff @(posedge clk) begin
            if (rst) begin
                table_q[s] <= '0;
            end else if (wr_en && (wr_sel == SLOT_ID)) begin
                table_q[s] <= wr_data;
            end
        end
        assign table_o[s] = table_q[s];
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (int'(rd_sel) == k) begin
                rd_data = table_q[k];
            end
        end
    end

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  tlb_entry_t          table_i [ENTRIES],
    input  logic [VPN_W-1:0]    vpn_i,
    input  logic [ASID_W-1:0]   asid_i,
    output logic                hit_o,
    output logic [IDX_W-1:0]    hit_idx_o
);

    logic [ENTRIES-1:0] match;

    for (genvar s = 0; s < ENTRIES; s++) begin : g_cmp
        logic vpn_eq;
        logic space_ok;
        assign vpn_eq   = (table_i[s].vpn2 == clear_vpn(vpn_i, table_i[s].mask));
        assign space_ok = table_i[s].glob || (table_i[s].asid == asid_i);
        assign match[s] = vpn_eq && space_ok;
    end

    // Scan from the top so the lowest matching slot is the last to land.
    always_comb begin
        hit_o     = 1'b0;
        hit_idx_o = '0;
        for (int k = ENTRIES - 1; k >= 0; k--) begin
            if (match[k]) begin
                hit_o     = 1'b1;
                hit_idx_o = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  op_i,
    input  logic [31:0] index_i,
    input  logic [31:0] random_i,
    input  logic [31:0] pagemask_i,
    input  logic [31:0] entryhi_i,
    input  logic [31:0] entrylo0_i,
    input  logic [31:0] entrylo1_i,
    output logic [31:0] index_o,
    output logic [31:0] pagemask_o,
    output logic [31:0] entryhi_o,
    output logic [31:0] entrylo0_o,
    output logic [31:0] entrylo1_o
);

    localparam int IDX_W = $clog2(ENTRIES);

    tlb_op_e             op;
    logic                wr_en;
    logic [WR_SEL_W-1:0] wr_sel;
    tlb_entry_t          wr_data;
    tlb_entry_t          rd_data;
    tlb_entry_t          table_w [ENTRIES];
    logic                hit;
    logic [IDX_W-1:0]    hit_idx;
    logic                unused_bits;

    always_comb begin
        case (op_i)
            3'd1:    op = OP_WRITE_IDX;
            3'd2:    op = OP_WRITE_RND;
            3'd3:    op = OP_READ;
            3'd4:    op = OP_PROBE;
            default: op = OP_IDLE;
        endcase
    end

    assign wr_en  = (op == OP_WRITE_IDX) || (op == OP_WRITE_RND);
    assign wr_sel = (op == OP_WRITE_RND) ? random_i[WR_SEL_W-1:0]
                                         : index_i[WR_SEL_W-1:0];

    assign wr_data = build_entry(pagemask_i[24:13], entryhi_i[31:13], entryhi_i[7:0],
                                 entrylo0_i[25:6], entrylo0_i[5:1], entrylo0_i[0],
                                 entrylo1_i[25:6], entrylo1_i[5:1], entrylo1_i[0]);

    assign unused_bits = ^{index_i[31:WR_SEL_W], random_i[31:WR_SEL_W],
                           pagemask_i[31:25], pagemask_i[12:0], entryhi_i[12:8],
                           entrylo0_i[31:26], entrylo1_i[31:26]};

    tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (index_i[RD_SEL_W-1:0]),
        .rd_data (rd_data),
        .table_o (table_w)
    );

    tlb_probe #(.ENTRIES(ENTRIES)) u_probe (
        .table_i   (table_w),
        .vpn_i     (entryhi_i[31:13]),
        .asid_i    (entryhi_i[7:0]),
        .hit_o     (hit),
        .hit_idx_o (hit_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            index_o <= '0;
        end else if (op == OP_PROBE) begin
            index_o <= hit ? {{(32-IDX_W){1'b0}}, hit_idx} : MISS_CODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pagemask_o <= '0;
            entryhi_o  <= '0;
            entrylo0_o <= '0;
            entrylo1_o <= '0;
        end else if (op == OP_READ) begin
            pagemask_o <= rb_mask(rd_data);
            entryhi_o  <= rb_hi(rd_data);
            entrylo0_o <= rb_lo(rd_data.pfn0, rd_data.fl0, rd_data.glob);
            entrylo1_o <= rb_lo(rd_data.pfn1, rd_data.fl1, rd_data.glob);
        end
    end

endmodule

// File: rtl/tlb_unit_chk.sv
module tlb_unit_chk #(
    parameter int ENTRIES = 48
) (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_i,
    input logic [31:0] index_o,
    input logic [31:0] pagemask_o,
    input logic [31:0] entryhi_o,
    input logic [31:0] entrylo0_o,
    input logic [31:0] entrylo1_o
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (index_o == 32'd0 && pagemask_o == 32'd0 && entryhi_o == 32'd0
                 && entrylo0_o == 32'd0 && entrylo1_o == 32'd0));

    // R9
    index_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != 3'd4) |=> $stable(index_o));

    // R9
    staging_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i != 3'd3) |=> ($stable(pagemask_o) && $stable(entryhi_o)
                            && $stable(entrylo0_o) && $stable(entrylo1_o)));

    // R7
    probe_range_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4) |=> (index_o == 32'h8000_0000 || index_o < ENTRIES));

    // R5
    readback_shape_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3) |=> (entryhi_o[12:8] == 5'd0 && pagemask_o[12:0] == 13'd0
                            && pagemask_o[31:25] == 7'd0 && entrylo0_o[31:26] == 6'd0));

    // R4
    global_fold_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3) |=> (entrylo0_o[0] == entrylo1_o[0]));

endmodule

bind tlb_unit tlb_unit_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_i       (op_i),
    .index_o    (index_o),
    .pagemask_o (pagemask_o),
    .entryhi_o  (entryhi_o),
    .entrylo0_o (entrylo0_o),
    .entrylo1_o (entrylo1_o)
);

// File: tb/tlb_unit_tb.sv
module tlb_unit_tb;

    localparam int ENTRIES = 48;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] index_i = '0, random_i = '0, pagemask_i = '0;
    logic [31:0] entryhi_i = '0, entrylo0_i = '0, entrylo1_i = '0;
    logic [31:0] index_o, pagemask_o, entryhi_o, entrylo0_o, entrylo1_o;

    always #10 clk = ~clk;

    tlb_unit #(.ENTRIES(ENTRIES)) u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .index_i(index_i), .random_i(random_i),
        .pagemask_i(pagemask_i), .entryhi_i(entryhi_i), .entrylo0_i(entrylo0_i),
        .entrylo1_i(entrylo1_i), .index_o(index_o), .pagemask_o(pagemask_o),
        .entryhi_o(entryhi_o), .entrylo0_o(entrylo0_o), .entrylo1_o(entrylo1_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] idx, pm, hi, lo0, lo1;
    } exp_t;

    exp_t sbq[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 0;

    // Reference table built from the field rules
    logic [11:0] m_mask [ENTRIES];
    logic [18:0] m_vpn  [ENTRIES];
    logic [7:0]  m_asid [ENTRIES];
    logic        m_g    [ENTRIES];
    logic [25:0] m_lo0  [ENTRIES];
    logic [25:0] m_lo1  [ENTRIES];
    logic [31:0] e_idx = '0, e_pm = '0, e_hi = '0, e_lo0 = '0, e_lo1 = '0;

    initial begin
        for (int i = 0; i < ENTRIES; i++) begin
            m_mask[i] = '0; m_vpn[i] = '0; m_asid[i] = '0;
            m_g[i] = 1'b0; m_lo0[i] = '0; m_lo1[i] = '0;
        end
    end

    task automatic model_step(input logic [2:0] op, input logic [31:0] idx, rnd,
                              pm, hi, lo0, lo1);
        int sel;
        logic [11:0] mk;
        case (op)
            3'd1, 3'd2: begin
                sel = (op == 3'd2) ? int'(rnd[5:0]) : int'(idx[5:0]);
                if (sel < ENTRIES) begin
                    mk = pm[24:13];
                    m_mask[sel] = mk;
                    m_vpn[sel]  = hi[31:13] & ~{7'b0, mk};
                    m_asid[sel] = hi[7:0];
                    m_g[sel]    = lo0[0] & lo1[0];
                    m_lo0[sel]  = {lo0[25:6] & ~{8'b0, mk}, lo0[5:1], 1'b0};
                    m_lo1[sel]  = {lo1[25:6] & ~{8'b0, mk}, lo1[5:1], 1'b0};
                end
            end
            3'd3: begin
                sel   = int'(idx[4:0]);
                e_pm  = {7'b0, m_mask[sel], 13'b0};
                e_hi  = {m_vpn[sel], 5'b0, m_asid[sel]};
                e_lo0 = {6'b0, m_lo0[sel][25:1], m_g[sel]};
                e_lo1 = {6'b0, m_lo1[sel][25:1], m_g[sel]};
            end
            3'd4: begin
                e_idx = 32'h8000_0000;
                for (int i = ENTRIES - 1; i >= 0; i--) begin
                    if (m_vpn[i] == (hi[31:13] & ~{7'b0, m_mask[i]}) &&
                        (m_g[i] || m_asid[i] == hi[7:0]))
                        e_idx = i;
                end
            end
            default: ;
        endcase
    endtask

    // Driver: apply one operation, advance one edge, push the expected outputs.
    task automatic drive(input logic [2:0] op, input logic [31:0] idx, rnd, pm,
                         hi, lo0, lo1, input string tag);
        exp_t e;
        op_i = op; index_i = idx; random_i = rnd; pagemask_i = pm;
        entryhi_i = hi; entrylo0_i = lo0; entrylo1_i = lo1;
        @(posedge clk);
        model_step(op, idx, rnd, pm, hi, lo0, lo1);
        e.tag = tag; e.idx = e_idx; e.pm = e_pm; e.hi = e_hi; e.lo0 = e_lo0; e.lo1 = e_lo1;
        sbq.push_back(e);
        @(negedge clk);
        op_i = 3'd0;
    endtask

    // Monitor: compare at the falling edge after the operation's edge.
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t e;
            e = sbq.pop_front();
            n_checks++;
            if (index_o !== e.idx || pagemask_o !== e.pm || entryhi_o !== e.hi ||
                entrylo0_o !== e.lo0 || entrylo1_o !== e.lo1) begin
                n_fail++;
                $display("FAIL %s: got idx=%h pm=%h hi=%h lo0=%h lo1=%h exp idx=%h pm=%h hi=%h lo0=%h lo1=%h",
                         e.tag, index_o, pagemask_o, entryhi_o, entrylo0_o, entrylo1_o,
                         e.idx, e.pm, e.hi, e.lo0, e.lo1);
            end
        end
    end

    task automatic direct_check(input string tag, input logic [31:0] got, exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of outputs and table
        drive(3'd0, 0, 0, 0, 0, 0, 0, "R1 reset outputs");
        drive(3'd3, 32'd5, 0, 0, 0, 0, 0, "R1 reset entry 5 readback");
        // R6: cleared entry 0 answers VPN2 0 / ASID 0 despite invalid
        drive(3'd4, 0, 0, 0, 32'h0000_0000, 0, 0, "R6 probe cleared entry 0");
        direct_check("R6 cleared entry 0 index", index_o, 32'd0);
        // R8: miss code
        drive(3'd4, 0, 0, 0, 32'h0000_0003, 0, 0, "R8 probe miss");
        direct_check("R8 miss code", index_o, 32'h8000_0000);
        // R4 R5: indexed write with mask, global, then read back
        drive(3'd1, 32'd7, 0, 32'h0000_6000, 32'hABCD_FF55, 32'hFC12_3457, 32'h0345_6783, "R4 write slot 7");
        drive(3'd3, 32'd7, 0, 0, 0, 0, 0, "R5 readback slot 7");
        // R2: upper index bits ignored; read-back wraps at 5 bits
        drive(3'd1, 32'hFFFF_FFC9, 0, 0, 32'h1234_5021, 32'h0000_1002, 32'h0000_2003, "R2 write via low index bits");
        drive(3'd3, 32'h0000_0029, 0, 0, 0, 0, 0, "R5 readback slot 9 via wrap");
        direct_check("R5 folded global on slot 9", entrylo1_o, 32'h0000_2002);
        // R2: random write uses random value, not index
        drive(3'd2, 32'd3, 32'h0000_0A0C, 32'h01FF_E000, 32'h7777_7042, 32'h03FF_FFFF, 32'h0000_0041, "R2 random write slot 12");
        drive(3'd3, 32'd12, 0, 0, 0, 0, 0, "R4 readback full mask slot 12");
        drive(3'd3, 32'd3, 0, 0, 0, 0, 0, "R2 index ignored by random write");
        // R3: out-of-range writes dropped
        drive(3'd1, 32'd50, 0, 0, 32'h5555_4011, 0, 0, "R3 write slot 50");
        drive(3'd4, 0, 0, 0, 32'h5555_4011, 0, 0, "R3 probe after slot 50");
        drive(3'd2, 0, 32'd63, 0, 32'h6666_6012, 0, 0, "R3 random write slot 63");
        drive(3'd4, 0, 0, 0, 32'h6666_6012, 0, 0, "R3 probe after slot 63");
        direct_check("R3 dropped write misses", index_o, 32'h8000_0000);
        // R6: global entry, masked VPN bits, other ASID
        drive(3'd4, 0, 0, 0, 32'hABCD_9F99, 0, 0, "R6 probe global masked");
        direct_check("R6 global masked hit", index_o, 32'd7);
        drive(3'd4, 0, 0, 0, 32'h1234_5022, 0, 0, "R6 probe ASID mismatch");
        drive(3'd4, 0, 0, 0, 32'h1234_5021, 0, 0, "R6 probe ASID match");
        // R7: duplicates, lowest slot wins
        drive(3'd1, 32'd30, 0, 0, 32'h4242_4007, 0, 0, "R9 write slot 30");
        drive(3'd1, 32'd20, 0, 0, 32'h4242_4007, 0, 0, "R9 write slot 20");
        drive(3'd4, 0, 0, 0, 32'h4242_4007, 0, 0, "R7 priority probe");
        direct_check("R7 lowest slot", index_o, 32'd20);
        // R10: illegal codes are idle
        drive(3'd6, 32'd5, 32'd5, 32'h0000_2000, 32'h1111_1001, 32'h41, 32'h41, "R10 op 6 idle");
        drive(3'd7, 32'd5, 32'd5, 32'h0000_2000, 32'h1111_1001, 32'h41, 32'h41, "R10 op 7 idle");
        drive(3'd5, 32'd5, 32'd5, 32'h0000_2000, 32'h1111_1001, 32'h41, 32'h41, "R10 op 5 idle");
        drive(3'd3, 32'd5, 0, 0, 0, 0, 0, "R10 slot 5 untouched");
        drive(3'd4, 0, 0, 0, 32'h1111_1001, 0, 0, "R10 probe after idle codes");
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule